// File: doc/BRIEF.md
# SPI command frame classifier

A target-side receiver for 16-bit serial command words. The controller pulls the chip select low, clocks the word in most significant bit first on rising serial clock edges, and then releases chip select. All serial inputs are brought into the system clock domain and oversampled there. When chip select returns high, the block classifies the captured word by its two top bits: register read, register write, flag read, or reserved. It splits out the address and data fields and checks bit 8. Bit 8 has a different meaning for each command kind.

Read commands of both kinds must carry a 1 in bit 8. A write carries 0 in bit 8 when parity is switched off. When parity is on, bit 8 of a write is an odd-parity bit. A word with any serial clock count other than 16 is dropped and reported as a framing error. The block has no register file and no response path.

Top module: `spi_cmd_classifier`

## Requirements
- R1: While rst_ni is low, cmd_valid_o, frame_err_o, pn_err_o, type_err_o, cmd_kind_o, addr_o and data_o are all zero.
- R2: A frame is the bits sampled on rising sclk_i edges while cs_ni is low, first bit into word bit 15. cmd_kind_o is word bits 15:14: 00 is a register read, 01 a register write, 11 a flag read. addr_o is word bits 13:9 and data_o is word bits 7:0.
- R3: Kind 10 is reserved. It produces cmd_valid_o with type_err_o = 1 and pn_err_o = 0.
- R4: For kinds 00 and 11, pn_err_o = 1 exactly when word bit 8 is 0. The value of parity_en_i does not change this.
- R5: For kind 01 with parity_en_i = 0, pn_err_o = 1 exactly when word bit 8 is 1.
- R6: For kind 01 with parity_en_i = 1, bit 8 must make the number of ones across all 16 word bits odd. pn_err_o = 1 when that count is even.
- R7: When a frame does not have exactly 16 rising sclk_i edges (0, 15, 17 or more), the block gives a one-cycle frame_err_o pulse and no cmd_valid_o. The next frame is then decoded normally.
- R8: cmd_valid_o or frame_err_o rises no later than the fifth rising clk_i edge after cs_ni rises. cmd_valid_o lasts exactly one cycle. There is one result per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| cs_ni | input | 1 | Frame select, active low, asynchronous |
| mosi_i | input | 1 | Serial data in |
| parity_en_i | input | 1 | Enables odd-parity checking of write bit 8 |
| cmd_valid_o | output | 1 | One-cycle pulse: a 16-bit frame has been classified |
| cmd_kind_o | output | 2 | Command kind, word bits 15:14 |
| addr_o | output | 5 | Register address, word bits 13:9 |
| data_o | output | 8 | Data field, word bits 7:0 |
| pn_err_o | output | 1 | Bit 8 rule violated for this kind |
| type_err_o | output | 1 | Reserved kind received |
| frame_err_o | output | 1 | One-cycle pulse: frame length was not 16 |

## Verification
A shift register that has slipped by one bit, or a stale edge detector, shows up as wrong addr_o, data_o or cmd_kind_o on the very pulse that ends the frame. A bit counter left over from the previous frame shows up as a spurious frame_err_o, or as a missing one, on the next frame. Every frame produces exactly one result within five clock edges of chip select rising, so any lost or extra internal event is seen at the ports by the following frame at the latest.

// File: rtl/spi_cls_pkg.sv
package spi_cls_pkg;
  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned KIND_HI    = 15;
  localparam int unsigned KIND_LO    = 14;
  localparam int unsigned ADDR_HI    = 13;
  localparam int unsigned ADDR_LO    = 9;
  localparam int unsigned PN_BIT     = 8;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned ADDR_W     = ADDR_HI - ADDR_LO + 1;
  localparam int unsigned KIND_W     = KIND_HI - KIND_LO + 1;

  typedef enum logic [KIND_W-1:0] {
    CMD_RD_REG  = 2'b00,
    CMD_WR_REG  = 2'b01,
    CMD_RSV     = 2'b10,
    CMD_RD_FLAG = 2'b11
  } cmd_kind_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned STAGES  = 2,
  parameter int unsigned W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= {STAGES{RST_VAL[b]}};
      else         chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/spi_frame_shift.sv
module spi_frame_shift
  import spi_cls_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_s_i,
  input  logic                  cs_n_s_i,
  input  logic                  mosi_s_i,
  output logic                  done_o,
  output logic                  len_ok_o,
  output logic [FRAME_BITS-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(FRAME_BITS + 2);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic                  sclk_q, cs_n_q;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-1:0] sh;
  logic                  sclk_rise, cs_rise;

  assign sclk_rise = sclk_s_i & ~sclk_q;
  assign cs_rise   = cs_n_s_i & ~cs_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      cnt      <= '0;
      sh       <= '0;
      done_o   <= 1'b0;
      len_ok_o <= 1'b0;
      word_o   <= '0;
    end else begin
      sclk_q <= sclk_s_i;
      cs_n_q <= cs_n_s_i;
      done_o <= cs_rise;
      if (cs_rise) begin
        word_o   <= sh;
        len_ok_o <= (cnt == CNT_FULL);
      end
      if (cs_n_s_i) begin
        cnt <= '0;
      end else if (sclk_rise) begin
        sh <= {sh[FRAME_BITS-2:0], mosi_s_i};
        // saturate one past full so long frames stay distinguishable
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
    end
  end

  p_idle_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> (cnt == '0));
endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_cls_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  done_i,
  input  logic                  len_ok_i,
  input  logic [FRAME_BITS-1:0] word_i,
  input  logic                  parity_en_i,
  output logic                  cmd_valid_o,
  output logic [KIND_W-1:0]     cmd_kind_o,
  output logic [ADDR_W-1:0]     addr_o,
  output logic [DATA_W-1:0]     data_o,
  output logic                  pn_err_o,
  output logic                  type_err_o,
  output logic                  frame_err_o
);
  cmd_kind_e kind;
  logic      exp_par, pn_bad, take;

  assign kind    = cmd_kind_e'(word_i[KIND_HI:KIND_LO]);
  // bit 8 value that makes the whole word carry an odd count of ones
  assign exp_par = ~^{word_i[FRAME_BITS-1:PN_BIT+1], word_i[PN_BIT-1:0]};
  assign take    = done_i & len_ok_i;

  always_comb begin
    unique case (kind)
      CMD_RD_REG, CMD_RD_FLAG: pn_bad = ~word_i[PN_BIT];
      CMD_WR_REG:              pn_bad = parity_en_i ? (word_i[PN_BIT] != exp_par)
                                                    : word_i[PN_BIT];
      default:                 pn_bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_valid_o <= 1'b0;
      frame_err_o <= 1'b0;
      cmd_kind_o  <= '0;
      addr_o      <= '0;
      data_o      <= '0;
      pn_err_o    <= 1'b0;
      type_err_o  <= 1'b0;
    end else begin
      cmd_valid_o <= take;
      frame_err_o <= done_i & ~len_ok_i;
      if (take) begin
        cmd_kind_o <= word_i[KIND_HI:KIND_LO];
        addr_o     <= word_i[ADDR_HI:ADDR_LO];
        data_o     <= word_i[DATA_W-1:0];
        pn_err_o   <= pn_bad;
        type_err_o <= (kind == CMD_RSV);
      end
    end
  end

  p_read_pn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && word_i[KIND_HI] == word_i[KIND_LO] && !word_i[PN_BIT]) |=> (cmd_valid_o && pn_err_o));
  p_wr_plain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && word_i[KIND_HI:KIND_LO] == 2'b01 && !parity_en_i && word_i[PN_BIT]) |=> pn_err_o);
  p_rsv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && word_i[KIND_HI:KIND_LO] == 2'b10) |=> (type_err_o && !pn_err_o));
  p_bad_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !len_ok_i) |=> (frame_err_o && !cmd_valid_o));
  p_one_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
endmodule

// File: rtl/spi_cmd_classifier.sv
module spi_cmd_classifier
  import spi_cls_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sclk_i,
  input  logic        cs_ni,
  input  logic        mosi_i,
  input  logic        parity_en_i,
  output logic        cmd_valid_o,
  output logic [1:0]  cmd_kind_o,
  output logic [4:0]  addr_o,
  output logic [7:0]  data_o,
  output logic        pn_err_o,
  output logic        type_err_o,
  output logic        frame_err_o
);
  logic [2:0]            sync_s;
  logic                  done, len_ok;
  logic [FRAME_BITS-1:0] word;

  spi_in_sync #(
    .STAGES (SYNC_STAGES),
    .W      (3),
    .RST_VAL(3'b010)
  ) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({mosi_i, cs_ni, sclk_i}),
    .sync_o (sync_s)
  );

  spi_frame_shift i_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_s_i(sync_s[0]),
    .cs_n_s_i(sync_s[1]),
    .mosi_s_i(sync_s[2]),
    .done_o  (done),
    .len_ok_o(len_ok),
    .word_o  (word)
  );

  spi_cmd_decode i_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done),
    .len_ok_i   (len_ok),
    .word_i     (word),
    .parity_en_i(parity_en_i),
    .cmd_valid_o(cmd_valid_o),
    .cmd_kind_o (cmd_kind_o),
    .addr_o     (addr_o),
    .data_o     (data_o),
    .pn_err_o   (pn_err_o),
    .type_err_o (type_err_o),
    .frame_err_o(frame_err_o)
  );

  p_result_follows_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> (cmd_valid_o || frame_err_o));
  p_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && frame_err_o));
endmodule

// File: tb/test_spi_cmd_classifier.sv
module test_spi_cmd_classifier;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, par_en = 1'b0;
  logic       cmd_valid, pn_err, type_err, frame_err;
  logic [1:0] kind;
  logic [4:0] addr;
  logic [7:0] data;

  spi_cmd_classifier i_spi_cmd_classifier (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .parity_en_i(par_en), .cmd_valid_o(cmd_valid), .cmd_kind_o(kind),
    .addr_o(addr), .data_o(data), .pn_err_o(pn_err), .type_err_o(type_err),
    .frame_err_o(frame_err)
  );

  typedef struct {
    bit         ferr;
    logic [1:0] kind;
    logic [4:0] addr;
    logic [7:0] data;
    bit         pn;
    bit         te;
    string      req;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  int   since = 0;
  logic cs_last = 1'b1;
  bit   vprev = 1'b0;
  bit   done_flag = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic send(input logic [15:0] w, input int nbits, input string req);
    exp_t e;
    e.req  = req;
    e.ferr = (nbits != 16);
    e.kind = w[15:14];
    e.addr = w[13:9];
    e.data = w[7:0];
    e.te   = (w[15:14] == 2'b10);
    case (w[15:14])
      2'b00, 2'b11: e.pn = !w[8];
      2'b01:        e.pn = par_en ? !(^w) : w[8];
      default:      e.pn = 1'b0;
    endcase
    q.push_back(e);
    @(negedge clk); cs_n = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      repeat (3) @(negedge clk); sclk = 1'b1;
      repeat (3) @(negedge clk); sclk = 1'b0;
    end
    repeat (3) @(negedge clk); cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  // cycles since chip select rose, counted at the design's clock edges
  always @(posedge clk) begin
    if (cs_n && !cs_last) since = 0;
    else                  since++;
    cs_last = cs_n;
  end

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && (cmd_valid || frame_err)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R8", "unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(since + 1 <= 5, "R8", "latency edges", since + 1, 5);
        if (e.ferr) begin
          chk(frame_err && !cmd_valid, "R7", "frame error only", {frame_err, cmd_valid}, 2'b10);
        end else begin
          chk(cmd_valid && !frame_err, e.req, "valid", {cmd_valid, frame_err}, 2'b10);
          chk(!vprev, "R8", "pulse width", vprev, 0);
          chk(kind == e.kind, "R2", "kind", kind, e.kind);
          chk(addr == e.addr, "R2", "addr", addr, e.addr);
          chk(data == e.data, "R2", "data", data, e.data);
          chk(pn_err == e.pn, e.req, "pn_err", pn_err, e.pn);
          chk(type_err == e.te, "R3", "type_err", type_err, e.te);
        end
      end
    end
    vprev = cmd_valid;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk({cmd_valid, frame_err, pn_err, type_err, kind, addr, data} == '0, "R1", "reset outputs",
        {cmd_valid, frame_err, pn_err, type_err, kind, addr, data}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    par_en = 1'b0;
    send(16'h2580, 16, "R2");
    send(16'h2480, 16, "R4");
    send(16'hC3A5, 16, "R2");
    send(16'hC2A5, 16, "R4");
    send(16'h60C0, 16, "R5");
    send(16'h61C0, 16, "R5");
    send(16'h8100, 16, "R3");
    send(16'hBE00, 16, "R3");

    par_en = 1'b1;
    send(16'h60C0, 16, "R6");
    send(16'h61C0, 16, "R6");
    send(16'h7FFF, 16, "R6");
    send(16'h7EFF, 16, "R6");
    send(16'h4000, 16, "R6");
    send(16'h2480, 16, "R4");
    send(16'hFF3C, 16, "R4");

    send(16'h2580, 15, "R7");
    send(16'h2580, 17, "R7");
    send(16'h0000, 0,  "R7");
    send(16'h5AB3, 16, "R7");

    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R8", "results pending", q.size(), 0);
    chk(!cmd_valid && !frame_err, "R8", "quiet after last", {cmd_valid, frame_err}, 0);
    done_flag = 1'b1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      report();
    end
  end
endmodule